// File: doc/BRIEF.md
# Arbitrated Multiply/Divide Unit

A compact arithmetic unit for unsigned operands (4 bits by default). Each cycle a three-state controller looks at two request lines and picks either the multiply path or the divide path. If neither line is raised, it parks in an idle state and flags a stall. The request is granted at a clock edge. At that same edge the two operands are loaded into input flip-flops. One clock later the selected result is loaded into output flip-flops, together with a one-cycle valid pulse.

The multiply path adds up shifted partial products. Each partial product is the first operand ANDed with one bit of the second operand. The divide path is a chain of restoring stages. Each stage subtracts the divisor from the partial remainder through a ripple-borrow subtractor. When that subtraction ends with a borrow, a multiplexer keeps the previous remainder. Division by zero finishes in the same fixed latency as any other division.

Controller states and transitions: `ST_STALL` (idle, stall raised), `ST_MUL` (multiply granted), `ST_DIV` (divide granted). From any state the next state is `ST_MUL` when `mul_req` is high. Otherwise it is `ST_DIV` when `div_req` is high. Otherwise it is `ST_STALL`. Multiply has priority.

Top module: `muldiv_arb_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to `ST_STALL`. After that edge `stall` is 1, `grant_mul`, `grant_div`, `res_valid` and `div_by_zero` are 0, and `product`, `quotient` and `remainder` are all zero.
- R2: If neither request is high at an edge, then after that edge `stall` is 1 and both grants are 0.
- R3: If `mul_req` is high at an edge, then after that edge `grant_mul` is 1 and `grant_div` and `stall` are 0. At most one of `grant_mul` and `grant_div` is ever high.
- R4: If `div_req` is high and `mul_req` is low at an edge, then after that edge `grant_div` is 1 and `grant_mul` and `stall` are 0.
- R5: If both requests are high at the same edge, multiply is granted and a product is returned.
- R6: A multiply granted at edge E puts `op_a*op_b` (as captured at E, `2W` bits wide) on `product` after edge E+1. `res_valid` is high for that one cycle only.
- R7: A divide granted at edge E with a non-zero divisor puts `op_a/op_b` on `quotient` and `op_a%op_b` on `remainder` after edge E+1, with `res_valid` high.
- R8: A divide with `op_b` = 0 returns `quotient` all ones (4'hF by default) and `remainder` equal to `op_a`. `div_by_zero` is high for exactly that one result cycle.
- R9: While the unit is stalled, `product`, `quotient` and `remainder` keep their values and `res_valid` stays 0.
- R10: A multiply result leaves `quotient` and `remainder` unchanged. A divide result leaves `product` unchanged.
- R11: Operands are used as they were at the granting edge. Changing `op_a` or `op_b` after that edge does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mul_req | input | 1 | Multiply request |
| div_req | input | 1 | Divide request |
| op_a | input | W | Multiplicand or dividend |
| op_b | input | W | Multiplier or divisor |
| product | output | 2W | Registered product |
| quotient | output | W | Registered quotient |
| remainder | output | W | Registered remainder |
| res_valid | output | 1 | One-cycle pulse when a new result is registered |
| grant_mul | output | 1 | Multiply currently granted |
| grant_div | output | 1 | Divide currently granted |
| stall | output | 1 | No operation granted |
| div_by_zero | output | 1 | The registered divide result had a zero divisor |

## Verification
The assertions assume the request lines are steady around the clock edge and take no value other than 0 or 1. They also assume the operands seen at a granting edge are the ones the result should come from. Nothing is assumed about operand values, so the arithmetic checks cover any value, including a zero divisor, which a separate property handles. The bench changes requests and operands only on the falling clock edge. It scrambles the operands right after each grant, so any late operand sampling would show up as a wrong result rather than a lucky match.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [1:0] {
        ST_STALL = 2'd0,
        ST_MUL   = 2'd1,
        ST_DIV   = 2'd2
    } mdu_state_e;
endpackage

// File: rtl/mdu_arbiter.sv
module mdu_arbiter
    import mdu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mul_req,
    input  logic       div_req,
    output mdu_state_e state_q,
    output logic       grant_mul,
    output logic       grant_div,
    output logic       stall
);
    mdu_state_e state_d;

    // priority-encoded next state: multiply first
    always_comb begin
        if (mul_req)      state_d = ST_MUL;
        else if (div_req) state_d = ST_DIV;
        else              state_d = ST_STALL;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STALL;
        else     state_q <= state_d;
    end

    always_comb begin
        grant_mul = 1'b0;
        grant_div = 1'b0;
        stall     = 1'b0;
        unique case (state_q)
            ST_MUL:   grant_mul = 1'b1;
            ST_DIV:   grant_div = 1'b1;
            ST_STALL: stall     = 1'b1;
            default:  stall     = 1'b1;
        endcase
    end
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_pp
        logic [PW-1:0] pp;
        assign pp         = {{W{1'b0}}, mcand & {W{mplier[i]}}} << i;
        assign acc[i + 1] = acc[i] + pp;
    end
    assign prod = acc[W];
endmodule

// File: rtl/mdu_div_stage.sv
module mdu_div_stage #(
    parameter int W = 4
) (
    input  logic [W:0]   part_in,
    input  logic [W-1:0] dvsr,
    output logic [W:0]   part_out,
    output logic         q_bit
);
    logic [W:0]   sub;
    logic [W:0]   diff;
    logic [W+1:0] brw;

    assign sub    = {1'b0, dvsr};
    assign brw[0] = 1'b0;
    for (genvar j = 0; j <= W; j++) begin : g_bit
        assign diff[j]    = part_in[j] ^ sub[j] ^ brw[j];
        assign brw[j + 1] = (~part_in[j] & sub[j]) | (~(part_in[j] ^ sub[j]) & brw[j]);
    end

    // restore mux: keep the old partial remainder on underflow
    assign q_bit    = ~brw[W+1];
    assign part_out = brw[W+1] ? part_in : diff;
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int W = 4
) (
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W:0] part [0:W];

    assign part[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_stage
        localparam int K = W - 1 - i;
        logic [W:0] stage_in;
        assign stage_in = {part[i][W-1:0], dvd[K]};
        mdu_div_stage #(.W(W)) stage_i (
            .part_in (stage_in),
            .dvsr    (dvsr),
            .part_out(part[i + 1]),
            .q_bit   (quo[K])
        );
    end
    assign rem = part[W][W-1:0];
endmodule

// File: rtl/muldiv_arb_unit.sv
module muldiv_arb_unit
    import mdu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mul_req,
    input  logic           div_req,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           res_valid,
    output logic           grant_mul,
    output logic           grant_div,
    output logic           stall,
    output logic           div_by_zero
);
    mdu_state_e     state_q;
    logic [W-1:0]   op_a_q;
    logic [W-1:0]   op_b_q;
    logic [2*W-1:0] prod_w;
    logic [W-1:0]   quo_w;
    logic [W-1:0]   rem_w;

    mdu_arbiter arb_i (
        .clk      (clk),
        .rst      (rst),
        .mul_req  (mul_req),
        .div_req  (div_req),
        .state_q  (state_q),
        .grant_mul(grant_mul),
        .grant_div(grant_div),
        .stall    (stall)
    );

    // input flip-flops: load only on a request edge
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (mul_req || div_req) begin
            op_a_q <= op_a;
            op_b_q <= op_b;
        end
    end

    mdu_mul #(.W(W)) mul_i (
        .mcand (op_a_q),
        .mplier(op_b_q),
        .prod  (prod_w)
    );

    mdu_div #(.W(W)) div_i (
        .dvd (op_a_q),
        .dvsr(op_b_q),
        .quo (quo_w),
        .rem (rem_w)
    );

    // output flip-flops
    always_ff @(posedge clk) begin
        if (rst) begin
            product     <= '0;
            quotient    <= '0;
            remainder   <= '0;
            res_valid   <= 1'b0;
            div_by_zero <= 1'b0;
        end else begin
            res_valid   <= 1'b0;
            div_by_zero <= 1'b0;
            unique case (state_q)
                ST_MUL: begin
                    product   <= prod_w;
                    res_valid <= 1'b1;
                end
                ST_DIV: begin
                    quotient    <= quo_w;
                    remainder   <= rem_w;
                    res_valid   <= 1'b1;
                    div_by_zero <= (op_b_q == '0);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           mul_req,
    input logic           div_req,
    input logic [W-1:0]   op_a_q,
    input logic [W-1:0]   op_b_q,
    input logic [2*W-1:0] product,
    input logic [W-1:0]   quotient,
    input logic [W-1:0]   remainder,
    input logic           res_valid,
    input logic           grant_mul,
    input logic           grant_div,
    input logic           stall,
    input logic           div_by_zero
);
    localparam int W2 = 2 * W;

    AST_IDLE_STALLS: assert property (@(posedge clk) disable iff (rst)
        (!mul_req && !div_req) |=> (stall && !grant_mul && !grant_div)); // R2
    AST_MUL_GRANTED: assert property (@(posedge clk) disable iff (rst)
        mul_req |=> (grant_mul && !grant_div && !stall)); // R3
    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(grant_mul && grant_div)); // R3
    AST_DIV_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (div_req && !mul_req) |=> (grant_div && !stall)); // R4
    AST_MUL_RESULT: assert property (@(posedge clk) disable iff (rst)
        grant_mul |=> (res_valid && product == W2'($past(op_a_q)) * W2'($past(op_b_q)))); // R6
    AST_DIV_RESULT: assert property (@(posedge clk) disable iff (rst)
        (grant_div && op_b_q != '0) |=>
        (res_valid && remainder < $past(op_b_q) &&
         W2'(quotient) * W2'($past(op_b_q)) + W2'(remainder) == W2'($past(op_a_q)))); // R7
    AST_DBZ_RESULT: assert property (@(posedge clk) disable iff (rst)
        div_by_zero |-> (res_valid && (&quotient))); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!res_valid && $stable(product) && $stable(quotient) && $stable(remainder))); // R9
    AST_MUL_KEEPS_DIV: assert property (@(posedge clk) disable iff (rst)
        grant_mul |=> ($stable(quotient) && $stable(remainder))); // R10
endmodule

bind muldiv_arb_unit mdu_checker #(.W(W)) chk_i (.*);

// File: tb/muldiv_arb_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_arb_unit_tb_top;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mul_req = 1'b0;
    logic           div_req = 1'b0;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic [2*W-1:0] product;
    logic [W-1:0]   quotient;
    logic [W-1:0]   remainder;
    logic           res_valid;
    logic           grant_mul;
    logic           grant_div;
    logic           stall;
    logic           div_by_zero;

    int n_cmp = 0;
    int n_mis = 0;
    logic [7:0] trk_p = '0;
    logic [3:0] trk_q = '0;
    logic [3:0] trk_r = '0;

    always #4 clk = ~clk;

    muldiv_arb_unit #(.W(W)) dut_i (.*);

    // {mul, div, a, b, product, quotient, remainder, dbz}
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'h3, 4'h5, 8'h0F, 4'h0, 4'h0, 1'b0},
        {1'b1, 1'b0, 4'hF, 4'hF, 8'hE1, 4'h0, 4'h0, 1'b0},
        {1'b0, 1'b1, 4'hD, 4'h3, 8'h00, 4'h4, 4'h1, 1'b0},
        {1'b1, 1'b0, 4'h0, 4'h9, 8'h00, 4'h0, 4'h0, 1'b0},
        {1'b0, 1'b1, 4'hF, 4'h1, 8'h00, 4'hF, 4'h0, 1'b0},
        {1'b0, 1'b1, 4'h7, 4'h9, 8'h00, 4'h0, 4'h7, 1'b0},
        {1'b0, 1'b1, 4'h9, 4'h0, 8'h00, 4'hF, 4'h9, 1'b1},
        {1'b1, 1'b1, 4'h6, 4'h7, 8'h2A, 4'h0, 4'h0, 1'b0},
        {1'b1, 1'b0, 4'h8, 4'h2, 8'h10, 4'h0, 4'h0, 1'b0},
        {1'b0, 1'b1, 4'hE, 4'h7, 8'h00, 4'h2, 4'h0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 stall", 16'(stall), 16'h1);
        chk("R1 grants", {grant_mul, grant_div}, 16'h0);
        chk("R1 valid/dbz", {res_valid, div_by_zero}, 16'h0);
        chk("R1 outputs", {product, quotient, remainder}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            mul_req = v[26];
            div_req = v[25];
            op_a    = v[24:21];
            op_b    = v[20:17];
            @(posedge clk);
            @(negedge clk);
            if (v[26]) chk(v[25] ? "R5 grant both" : "R3 grant", {grant_mul, grant_div, stall}, 16'b100);
            else       chk("R4 grant", {grant_mul, grant_div, stall}, 16'b010);
            mul_req = 1'b0;
            div_req = 1'b0;
            op_a    = ~op_a;          // R11: late operand change
            op_b    = ~op_b;
            @(posedge clk);
            @(negedge clk);
            chk("R6 valid", 16'(res_valid), 16'h1);
            chk("R2 stall after idle", {stall, grant_mul, grant_div}, 16'b100);
            if (v[26]) begin
                trk_p = v[16:9];
                chk(v[25] ? "R5 product" : "R6 R11 product", 16'(product), 16'(trk_p));
                chk("R10 q/r kept", {quotient, remainder}, {trk_q, trk_r});
                chk("R8 dbz low", 16'(div_by_zero), 16'h0);
            end else begin
                trk_q = v[8:5];
                trk_r = v[4:1];
                chk(v[0] ? "R8 q/r" : "R7 R11 q/r", {quotient, remainder}, {trk_q, trk_r});
                chk("R8 dbz", 16'(div_by_zero), 16'(v[0]));
                chk("R10 product kept", 16'(product), 16'(trk_p));
            end
        end

        // one-cycle valid, then hold while stalled
        @(posedge clk);
        @(negedge clk);
        chk("R6 valid one cycle", 16'(res_valid), 16'h0);
        op_a = 4'h5;
        op_b = 4'hB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 hold", {product, quotient, remainder}, {trk_p, trk_q, trk_r});
        chk("R9 valid low", 16'(res_valid), 16'h0);

        // div-by-zero flag lasts one cycle
        div_req = 1'b1;
        op_a = 4'hC;
        op_b = 4'h0;
        @(posedge clk);
        @(negedge clk);
        div_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 dbz q/r", {div_by_zero, quotient, remainder}, {1'b1, 4'hF, 4'hC});
        @(posedge clk);
        @(negedge clk);
        chk("R8 dbz one cycle", 16'(div_by_zero), 16'h0);

        // back-to-back multiplies with request held
        mul_req = 1'b1;
        op_a = 4'h2; op_b = 4'h3;
        @(posedge clk);
        @(negedge clk);
        op_a = 4'h4; op_b = 4'h5;
        @(posedge clk);
        @(negedge clk);
        mul_req = 1'b0;
        chk("R6 first of pair", {7'h0, res_valid, product}, {8'h1, 8'h06});
        @(posedge clk);
        @(negedge clk);
        chk("R6 second of pair", {7'h0, res_valid, product}, {8'h1, 8'h14});

        // reset in the middle of an operation
        div_req = 1'b1;
        op_a = 4'h9; op_b = 4'h2;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        div_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset", {res_valid, stall, product, quotient, remainder}, {1'b0, 1'b1, 16'h0});
        chk("R1 mid reset grants", {grant_mul, grant_div, div_by_zero}, 16'h0);

        summary();
    end
endmodule